// File: doc/BRIEF.md
# PCM Frame Timing Generator

This block supplies the timing skeleton of a serial PCM audio port. It either produces the bit clock and the frame sync itself or follows them from the pins. It reports each sampling and driving edge of the bit clock as a one-cycle strobe in the system clock domain, and it keeps a bit index that locates the current bit inside the frame. A channel shifter placed next to it uses the strobes and the index to decide when to shift and which bits belong to which channel.

The frame length, the number of bit clocks the sync stays active, the sampling edge and the sync polarity are all programmable. The bit clock and the frame sync each have their own slave select, so any mix of master and slave is possible. In master clock mode the bit clock toggles once for every enable strobe from the system clock. In slave sync mode a frame-start transition seen on the sync pin forces the index back to zero at the next sampling edge.

Top module: `pcm_frame_timer`

## Requirements
- R1: While reset is held and on the first cycle after it: bit_idx is all ones (1023), sample_stb, drive_stb, frame_start and bclk_out are 0, and fsync_out sits at its inactive level, which is 0 when sync_fall_start=0 and 1 when it is 1.
- R2: In master clock mode (bclk_slave=0), with clk_off=0, bclk_out inverts one system clock after each cycle in which bclk_tick is 1. In slave clock mode bclk_out is held at 0.
- R3: When sample_rise=1 the sampling edge is the rising bit-clock edge, and when it is 0 the sampling edge is the falling edge. The opposite edge is the driving edge. sample_stb and drive_stb are each a one-cycle pulse in the cycle after their edge, and the two never pulse together.
- R4: bit_idx changes only when sample_stb is 1. At each sampling edge it advances by one, and after the value frame_len_m1 it returns to 0, so a frame is frame_len_m1+1 bits long (1 to 1024). The first sampling edge after reset gives index 0.
- R5: frame_start pulses, together with sample_stb, exactly when bit_idx takes the value 0.
- R6: In master sync mode (fsync_slave=0), fsync_out is updated on each driving edge. It is active for the bit about to be driven when that bit's index is below sync_len, so a sync_len of 0 never asserts it and a sync_len at or above the frame length holds it active. It is active high when sync_fall_start=0 and active low when sync_fall_start=1.
- R7: In slave sync mode, fsync_in passes through a two-flop synchronizer. A change of fsync_in into its active level (high when sync_fall_start=0, low when 1) makes the next sampling edge load bit_idx with 0 and pulse frame_start. In this mode fsync_out is held at 0.
- R8: While clk_off=1, the bit clock does not toggle, no strobes are produced and bit_idx holds its value.
- R9: In slave clock mode, bclk_in passes through a two-flop synchronizer, and each of its edges produces exactly one sample_stb or drive_stb, selected as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_tick | input | 1 | Half-period enable for the master bit clock |
| clk_off | input | 1 | Stops bit-clock activity |
| bclk_slave | input | 1 | 1: follow bclk_in; 0: drive bclk_out |
| fsync_slave | input | 1 | 1: follow fsync_in; 0: drive fsync_out |
| sample_rise | input | 1 | 1: sample on rising bit-clock edge |
| sync_fall_start | input | 1 | 1: frame sync is active low |
| frame_len_m1 | input | 10 | Frame length minus one, in bits |
| sync_len | input | 10 | Sync active length in bits |
| bclk_in | input | 1 | External bit clock |
| fsync_in | input | 1 | External frame sync |
| bclk_out | output | 1 | Driven bit clock |
| fsync_out | output | 1 | Driven frame sync |
| sample_stb | output | 1 | Sampling-edge strobe |
| drive_stb | output | 1 | Driving-edge strobe |
| frame_start | output | 1 | Index-zero strobe |
| bit_idx | output | 10 | Index of the last sampled bit |

## Verification
The properties assume that frame_len_m1, sample_rise and the mode selects stay fixed while the bit clock is running, and that the slave pins change slowly compared with the system clock. The bench changes configuration only while reset is held or while ticks are stopped. It moves bclk_in and fsync_in at most once every five system cycles, so each pin edge crosses the synchronizer on its own.

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_tick,
  input  logic             clk_off,
  input  logic             bclk_slave,
  input  logic             fsync_slave,
  input  logic             sample_rise,
  input  logic             sync_fall_start,
  input  logic [IDX_W-1:0] frame_len_m1,
  input  logic [IDX_W-1:0] sync_len,
  input  logic             bclk_in,
  input  logic             fsync_in,
  output logic             bclk_out,
  output logic             fsync_out,
  output logic             sample_stb,
  output logic             drive_stb,
  output logic             frame_start,
  output logic [IDX_W-1:0] bit_idx
);

  logic             bck, fs_act, pend;
  logic [2:0]       bsync, fsync;
  logic [IDX_W-1:0] cnt;

  wire edge_ev = !clk_off && (bclk_slave ? (bsync[1] ^ bsync[2]) : bclk_tick);
  wire new_lvl = bclk_slave ? bsync[1] : ~bck;
  wire samp_ev = edge_ev && (new_lvl == sample_rise);
  wire drv_ev  = edge_ev && (new_lvl != sample_rise);

  wire [IDX_W-1:0] nxt = (cnt >= frame_len_m1) ? '0 : cnt + IDX_W'(1);
  wire fs_edge = fsync_slave && (fsync[1] ^ sync_fall_start) && !(fsync[2] ^ sync_fall_start);
  wire resync  = fsync_slave && (pend || fs_edge);
  wire [IDX_W-1:0] cnt_d = resync ? '0 : nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck         <= 1'b0;
      bsync       <= '0;
      fsync       <= '0;
      pend        <= 1'b0;
      fs_act      <= 1'b0;
      cnt         <= '1;
      sample_stb  <= 1'b0;
      drive_stb   <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      bsync       <= {bsync[1:0], bclk_in};
      fsync       <= {fsync[1:0], fsync_in};
      sample_stb  <= samp_ev;
      drive_stb   <= drv_ev;
      frame_start <= samp_ev && (cnt_d == '0);
      if (!bclk_slave && edge_ev) bck <= ~bck;
      if (samp_ev) cnt <= cnt_d;
      if (samp_ev) pend <= 1'b0;
      else if (fs_edge) pend <= 1'b1;
      if (drv_ev) fs_act <= (nxt < sync_len);
    end
  end

  assign bit_idx   = cnt;
  assign bclk_out  = bclk_slave ? 1'b0 : bck;
  assign fsync_out = fsync_slave ? 1'b0 : (fs_act ^ sync_fall_start);

endmodule

// File: rtl/pcm_frame_timer_chk.sv
module pcm_frame_timer_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_off,
  input logic [IDX_W-1:0] frame_len_m1,
  input logic             sample_stb,
  input logic             drive_stb,
  input logic             frame_start,
  input logic [IDX_W-1:0] bit_idx
);

  p_strobes_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && drive_stb));

  p_idx_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (bit_idx <= frame_len_m1));

  p_idx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(bit_idx));

  p_start_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (sample_stb && bit_idx == '0));

  p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_off |=> (!sample_stb && !drive_stb));

endmodule

bind pcm_frame_timer pcm_frame_timer_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/pcm_frame_timer_test.sv
module pcm_frame_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk_tick = 1'b0, clk_off = 1'b0, bclk_slave = 1'b0, fsync_slave = 1'b0;
  logic       sample_rise = 1'b1, sync_fall_start = 1'b0;
  logic [9:0] frame_len_m1 = 10'd7, sync_len = 10'd1;
  logic       bclk_in = 1'b0, fsync_in = 1'b0;
  logic       bclk_out, fsync_out, sample_stb, drive_stb, frame_start;
  logic [9:0] bit_idx;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  pcm_frame_timer uut (.*);

  // {frame_len_m1, sync_len, sample_rise, sync_fall_start, expected frame starts in 40 samples}
  localparam int NV = 6;
  localparam logic [29:0] VEC [NV] = '{
    {10'd7,  10'd1,  1'b1, 1'b0, 8'd5},
    {10'd15, 10'd8,  1'b0, 1'b1, 8'd3},
    {10'd0,  10'd1,  1'b1, 1'b0, 8'd40},
    {10'd9,  10'd3,  1'b0, 1'b0, 8'd4},
    {10'd4,  10'd0,  1'b1, 1'b1, 8'd8},
    {10'd3,  10'd10, 1'b0, 1'b1, 8'd10}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    sync_fall_start = 1'b1;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(bit_idx == 10'd1023, "R1 idx", bit_idx, 1023);
    chk(!sample_stb && !drive_stb && !frame_start, "R1 strobes", sample_stb + drive_stb + frame_start, 0);
    chk(bclk_out == 1'b0, "R1 bclk", bclk_out, 0);
    chk(fsync_out == 1'b1, "R1 fsync", fsync_out, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_idx == 10'd1023 && !sample_stb, "R1 after release", bit_idx, 1023);

    // table-driven master runs
    for (int v = 0; v < NV; v++) begin
      int flm1, slen, exp_starts, samples, starts, toggles, cyc, ls, nx, bad4, bad5, bad6, bad3;
      logic prev_b;
      flm1 = VEC[v][29:20];
      slen = VEC[v][19:10];
      exp_starts = VEC[v][7:0];
      rst_n = 1'b0;
      bclk_tick = 1'b0;
      frame_len_m1 = VEC[v][29:20];
      sync_len = VEC[v][19:10];
      sample_rise = VEC[v][9];
      sync_fall_start = VEC[v][8];
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      prev_b = bclk_out;
      bclk_tick = 1'b1;
      samples = 0; starts = 0; toggles = 0; cyc = 0; ls = -1;
      bad3 = 0; bad4 = 0; bad5 = 0; bad6 = 0;
      while (samples < 40 && cyc < 200) begin
        @(negedge clk);
        cyc++;
        if (bclk_out != prev_b) toggles++;
        prev_b = bclk_out;
        nx = (ls < 0 || ls >= flm1) ? 0 : ls + 1;
        if (sample_stb && drive_stb) bad3++;
        if (sample_stb) begin
          if (bclk_out != sample_rise) bad3++;
          if (bit_idx != nx) bad4++;
          if (frame_start != (nx == 0)) bad5++;
          if (frame_start) starts++;
          ls = nx;
          samples++;
        end
        if (drive_stb) begin
          if (bclk_out == sample_rise) bad3++;
          if (fsync_out != ((nx < slen) ^ sync_fall_start)) bad6++;
        end
      end
      bclk_tick = 1'b0;
      chk(toggles == cyc, "R2 toggle per tick", toggles, cyc);
      chk(bad3 == 0, "R3 edge selection", bad3, 0);
      chk(bad4 == 0, "R4 index sequence", bad4, 0);
      chk(bad5 == 0 && starts == exp_starts, "R5 frame starts", starts, exp_starts);
      chk(bad6 == 0, "R6 sync level", bad6, 0);
    end

    // R8: clock off freezes everything
    begin
      logic [9:0] hold_idx;
      logic hold_b;
      int bad;
      rst_n = 1'b0;
      frame_len_m1 = 10'd7; sync_len = 10'd1; sample_rise = 1'b1; sync_fall_start = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      bclk_tick = 1'b1;
      repeat (5) @(negedge clk);
      clk_off = 1'b1;
      @(negedge clk);
      hold_idx = bit_idx;
      hold_b = bclk_out;
      bad = 0;
      repeat (10) begin
        @(negedge clk);
        if (sample_stb || drive_stb || bit_idx != hold_idx || bclk_out != hold_b) bad++;
      end
      chk(bad == 0, "R8 frozen while off", bad, 0);
      chk(hold_idx == 10'd2, "R8 index kept", hold_idx, 2);
      clk_off = 1'b0;
      bclk_tick = 1'b0;
    end

    // R9: slave bit clock
    begin
      int ns, nd;
      rst_n = 1'b0;
      bclk_slave = 1'b1; bclk_in = 1'b0; sample_rise = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      bclk_in = 1'b1;
      ns = 0; nd = 0;
      repeat (5) begin
        @(negedge clk);
        if (sample_stb) ns++;
        if (drive_stb) nd++;
      end
      chk(ns == 1 && nd == 0, "R9 rising gives sample", ns, 1);
      chk(bit_idx == 10'd0, "R9 index after first sample", bit_idx, 0);
      chk(bclk_out == 1'b0, "R2 bclk held in slave", bclk_out, 0);
      bclk_in = 1'b0;
      ns = 0; nd = 0;
      repeat (5) begin
        @(negedge clk);
        if (sample_stb) ns++;
        if (drive_stb) nd++;
      end
      chk(nd == 1 && ns == 0, "R9 falling gives drive", nd, 1);
      bclk_slave = 1'b0;
    end

    // R7: slave frame sync realigns the index
    begin
      int guard;
      rst_n = 1'b0;
      fsync_slave = 1'b1; sync_fall_start = 1'b1; fsync_in = 1'b1;
      frame_len_m1 = 10'd15; sample_rise = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      bclk_tick = 1'b1;
      repeat (12) @(negedge clk);
      bclk_tick = 1'b0;
      chk(bit_idx == 10'd5, "R4 mid-frame index", bit_idx, 5);
      fsync_in = 1'b0;
      repeat (5) @(negedge clk);
      chk(bit_idx == 10'd5 && fsync_out == 1'b0, "R7 no change without edge, fsync_out low", bit_idx, 5);
      bclk_tick = 1'b1;
      guard = 0;
      do begin
        @(negedge clk);
        guard++;
      end while (!sample_stb && guard < 10);
      bclk_tick = 1'b0;
      chk(bit_idx == 10'd0, "R7 realigned index", bit_idx, 0);
      chk(frame_start == 1'b1, "R7 frame start on realign", frame_start, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule